// File: doc/BRIEF.md
# Two-Level Prioritized Interrupt Controller

This unit arbitrates interrupt requests for a small 8-bit microcontroller core. It treats each clock as one machine cycle. At every clock edge it captures the twelve request flags raised by the peripherals. During the following cycle it polls the captured copy. A captured request counts only when its own enable bit and the global enable are both set. It is then sorted into the high or low level by its priority bit. Within a level, a fixed polling order picks one winner.

A winner is vectored only when three things hold. The current cycle must be the final cycle of the executing instruction. That instruction must not be a return-from-interrupt or a write to the enable or priority registers. No handler of the same or a higher level may be in service. When a winner is vectored, the unit raises a one-cycle call strobe for the core. Alongside it come the 16-bit service address and a clear strobe for flags that hardware is allowed to clear. The core performs the actual call, which pushes only the program counter.

The in-service tracking is a four-state machine:
- `ISV_IDLE`: nothing is in service.
- `ISV_LOW`: a low handler is running.
- `ISV_HIGH`: a high handler is running.
- `ISV_NESTED`: a high handler has preempted a low one.

Transitions:
- A low call moves `ISV_IDLE` to `ISV_LOW`.
- A high call moves `ISV_IDLE` to `ISV_HIGH`, and `ISV_LOW` to `ISV_NESTED`.
- A return moves `ISV_NESTED` to `ISV_LOW`, and moves `ISV_HIGH` or `ISV_LOW` to `ISV_IDLE`.

Top module: `irq_two_level_ctrl`

## Requirements
- R1: A flag raised for one cycle k yields `call_req` high in cycle k+2 only, as a single-cycle strobe, when nothing blocks it.
- R2: A source whose `src_en` bit is 0, or any source while `glob_en` is 0, is never vectored.
- R3: An enabled high-level request (`prio_hi` bit 1) wins over any low-level request, whatever their polling positions.
- R4: Within one level, the lowest index wins. The indices, in polling order, are 0 ext0, 1 expansion serial port, 2 ext2, 3 timer0, 4 ext3, 5 ext1, 6 ext4, 7 timer1, 8 ext5, 9 serial, 10 timer2, 11 ext6.
- R5: `call_vec` carries the address of the winning index. The addresses by index 0..11 are 0x0003, 0x004B, 0x0053, 0x000B, 0x005B, 0x0013, 0x0063, 0x001B, 0x006B, 0x0023, 0x002B, 0x0073.
- R6: No call is issued from a poll cycle in which `last_cycle` is 0.
- R7: No call is issued from a poll cycle in which `ret_in` or `cfg_wr` is 1.
- R8: A request that was present only while blocked, and is gone by the time the block lifts, is never vectored.
- R9: While a low handler is in service, low requests are held off and high requests are taken. While a high handler is in service, all requests are held off.
- R10: `ret_in` ends the highest level in service; a preempted low handler stays in service.
- R11: With the call, `flag_clr` pulses the winner's bit for indices 2, 3, 4, 6, 7, 8 and 11. It pulses index 0 when `edge_ext[0]` is 1, and index 5 when `edge_ext[1]` is 1. It stays 0 for indices 1, 9 and 10.
- R12: After reset, `call_req` and `flag_clr` are 0 and no level is in service.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, one machine cycle per period |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_flags | input | 12 | Request flags in polling order |
| src_en | input | 12 | Per-source enable |
| glob_en | input | 1 | Global enable |
| prio_hi | input | 12 | Per-source level, 1 = high |
| edge_ext | input | 2 | Bit 0: ext0 is edge-triggered; bit 1: ext1 is edge-triggered |
| last_cycle | input | 1 | Current cycle is the final cycle of the instruction |
| ret_in | input | 1 | Current instruction is a return-from-interrupt (final cycle) |
| cfg_wr | input | 1 | Current instruction writes the enable or priority register |
| call_req | output | 1 | One-cycle call request strobe |
| call_vec | output | 16 | Service address for the call |
| flag_clr | output | 12 | One-cycle hardware clear strobe per source |

## Verification
Single-source pulses on every index separate the address and flag-clear maps from the priority logic. Pulses with all flags raised, and with scattered pairs, expose wrong polling order. Pairs that mix levels show whether level takes precedence over position.

Requests held across non-final cycles, and across return or register-write cycles, show whether blocking takes effect. Dropping such a request before the block lifts shows that no pending state is kept.

A nested sequence of low call, high preempt, returns and retries tells apart each of the four in-service states. A long random run with a behavioural model compared on every clock catches interactions the directed cases miss.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
    localparam int unsigned IRQ_SRCS = 12;
    localparam int unsigned VEC_W    = 16;

    typedef enum logic [1:0] {
        ISV_IDLE   = 2'd0,
        ISV_LOW    = 2'd1,
        ISV_HIGH   = 2'd2,
        ISV_NESTED = 2'd3
    } isv_state_e;

    // service address for a polling-order index
    function automatic logic [VEC_W-1:0] vec_of(input int unsigned idx);
        logic [VEC_W-1:0] a;
        case (idx)
            0:       a = 16'h0003;
            1:       a = 16'h004B;
            2:       a = 16'h0053;
            3:       a = 16'h000B;
            4:       a = 16'h005B;
            5:       a = 16'h0013;
            6:       a = 16'h0063;
            7:       a = 16'h001B;
            8:       a = 16'h006B;
            9:       a = 16'h0023;
            10:      a = 16'h002B;
            11:      a = 16'h0073;
            default: a = '0;
        endcase
        return a;
    endfunction

    // whether hardware may clear the flag of this index on vectoring
    function automatic logic hw_clears(input int unsigned idx, input logic [1:0] edge_ext);
        logic c;
        case (idx)
            0:         c = edge_ext[0];
            5:         c = edge_ext[1];
            1, 9, 10:  c = 1'b0;
            default:   c = 1'b1;
        endcase
        return c;
    endfunction
endpackage

// File: rtl/irqc_sampler.sv
module irqc_sampler #(
    parameter int unsigned N = irqc_pkg::IRQ_SRCS
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] flags,
    output logic [N-1:0] samp
);
    // captured copy polled during the following cycle
    always_ff @(posedge clk) begin
        if (!rst_n) samp <= '0;
        else        samp <= flags;
    end
endmodule

// File: rtl/irqc_first_set.sv
module irqc_first_set #(
    parameter int unsigned N  = irqc_pkg::IRQ_SRCS,
    localparam int unsigned IW = $clog2(N)
) (
    input  logic [N-1:0]  req,
    output logic          any,
    output logic [IW-1:0] idx
);
    // lowest index wins: scan downward so the last hit is the smallest
    always_comb begin
        idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) idx = IW'(i);
        end
    end
    assign any = |req;
endmodule

// File: rtl/irqc_resolver.sv
module irqc_resolver #(
    parameter int unsigned N  = irqc_pkg::IRQ_SRCS,
    localparam int unsigned IW = $clog2(N)
) (
    input  logic [N-1:0]  samp,
    input  logic [N-1:0]  src_en,
    input  logic          glob_en,
    input  logic [N-1:0]  prio_hi,
    input  logic          allow_hi,
    input  logic          allow_lo,
    output logic          win_valid,
    output logic          win_hi,
    output logic [IW-1:0] win_idx
);
    logic [N-1:0]  live;
    logic [1:0][N-1:0]  lvl_req;
    logic [1:0]         lvl_any;
    logic [1:0][IW-1:0] lvl_idx;

    assign live       = samp & src_en & {N{glob_en}};
    assign lvl_req[0] = live & ~prio_hi;
    assign lvl_req[1] = live & prio_hi;

    // one fixed-order encoder per priority level
    for (genvar g = 0; g < 2; g++) begin : g_lvl
        irqc_first_set #(.N(N)) u_enc (
            .req (lvl_req[g]),
            .any (lvl_any[g]),
            .idx (lvl_idx[g])
        );
    end

    always_comb begin
        win_valid = 1'b0;
        win_hi    = 1'b0;
        win_idx   = '0;
        if (lvl_any[1] && allow_hi) begin
            win_valid = 1'b1;
            win_hi    = 1'b1;
            win_idx   = lvl_idx[1];
        end else if (lvl_any[0] && allow_lo) begin
            win_valid = 1'b1;
            win_idx   = lvl_idx[0];
        end
    end
endmodule

// File: rtl/irqc_isv_fsm.sv
module irqc_isv_fsm #(
    parameter int unsigned N     = irqc_pkg::IRQ_SRCS,
    parameter int unsigned VW    = irqc_pkg::VEC_W,
    localparam int unsigned IW   = $clog2(N)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          last_cycle,
    input  logic          ret_in,
    input  logic          cfg_wr,
    input  logic [1:0]    edge_ext,
    input  logic          win_valid,
    input  logic          win_hi,
    input  logic [IW-1:0] win_idx,
    output logic          allow_hi,
    output logic          allow_lo,
    output logic          call_req,
    output logic [VW-1:0] call_vec,
    output logic [N-1:0]  flag_clr
);
    import irqc_pkg::*;

    isv_state_e   state_q, state_d;
    logic         boundary;
    logic [N-1:0] clr_d;

    assign boundary = last_cycle & ~ret_in & ~cfg_wr;
    assign allow_hi = boundary & ((state_q == ISV_IDLE) | (state_q == ISV_LOW));
    assign allow_lo = boundary & (state_q == ISV_IDLE);

    always_comb begin
        state_d = state_q;
        if (ret_in) begin
            unique case (state_q)
                ISV_NESTED: state_d = ISV_LOW;
                ISV_HIGH:   state_d = ISV_IDLE;
                ISV_LOW:    state_d = ISV_IDLE;
                ISV_IDLE:   state_d = ISV_IDLE;
            endcase
        end else if (win_valid) begin
            unique case (state_q)
                ISV_IDLE:   state_d = win_hi ? ISV_HIGH : ISV_LOW;
                ISV_LOW:    state_d = ISV_NESTED;
                ISV_HIGH:   state_d = ISV_HIGH;
                ISV_NESTED: state_d = ISV_NESTED;
            endcase
        end
    end

    for (genvar g = 0; g < N; g++) begin : g_clr
        assign clr_d[g] = win_valid && (win_idx == IW'(g)) && hw_clears(g, edge_ext);
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ISV_IDLE;
        else        state_q <= state_d;
    end

    // registered outputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            call_req <= 1'b0;
            call_vec <= '0;
            flag_clr <= '0;
        end else begin
            call_req <= win_valid;
            flag_clr <= clr_d;
            if (win_valid) call_vec <= vec_of(32'(win_idx));
        end
    end

    p_nonfinal_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !last_cycle |=> !call_req);
    p_ret_cfg_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (ret_in || cfg_wr) |=> !call_req);
    p_high_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ISV_HIGH || state_q == ISV_NESTED) |=> !call_req);
endmodule

// File: rtl/irq_two_level_ctrl.sv
module irq_two_level_ctrl #(
    parameter int unsigned N  = irqc_pkg::IRQ_SRCS,
    parameter int unsigned VW = irqc_pkg::VEC_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [N-1:0]  irq_flags,
    input  logic [N-1:0]  src_en,
    input  logic          glob_en,
    input  logic [N-1:0]  prio_hi,
    input  logic [1:0]    edge_ext,
    input  logic          last_cycle,
    input  logic          ret_in,
    input  logic          cfg_wr,
    output logic          call_req,
    output logic [VW-1:0] call_vec,
    output logic [N-1:0]  flag_clr
);
    localparam int unsigned IW = $clog2(N);

    logic [N-1:0]  samp;
    logic          allow_hi, allow_lo;
    logic          win_valid, win_hi;
    logic [IW-1:0] win_idx;

    irqc_sampler #(.N(N)) u_samp (
        .clk   (clk),
        .rst_n (rst_n),
        .flags (irq_flags),
        .samp  (samp)
    );

    irqc_resolver #(.N(N)) u_res (
        .samp      (samp),
        .src_en    (src_en),
        .glob_en   (glob_en),
        .prio_hi   (prio_hi),
        .allow_hi  (allow_hi),
        .allow_lo  (allow_lo),
        .win_valid (win_valid),
        .win_hi    (win_hi),
        .win_idx   (win_idx)
    );

    irqc_isv_fsm #(.N(N), .VW(VW)) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .last_cycle (last_cycle),
        .ret_in     (ret_in),
        .cfg_wr     (cfg_wr),
        .edge_ext   (edge_ext),
        .win_valid  (win_valid),
        .win_hi     (win_hi),
        .win_idx    (win_idx),
        .allow_hi   (allow_hi),
        .allow_lo   (allow_lo),
        .call_req   (call_req),
        .call_vec   (call_vec),
        .flag_clr   (flag_clr)
    );

    p_gate_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !glob_en |=> !call_req);
    p_clr_with_call_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (|flag_clr) |-> call_req);
endmodule

// File: tb/irq_two_level_ctrl_tb.sv
`timescale 1ns/1ps
module irq_two_level_ctrl_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [11:0] irq_flags = '0, src_en = '1, prio_hi = '0;
    logic        glob_en = 1'b1, last_cycle = 1'b1, ret_in = 1'b0, cfg_wr = 1'b0;
    logic [1:0]  edge_ext = 2'b01;
    logic        call_req;
    logic [15:0] call_vec;
    logic [11:0] flag_clr;

    int checks = 0, failures = 0;
    bit done = 0;
    string cur_tag = "R12";

    always #2.5 clk = ~clk;

    irq_two_level_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .irq_flags(irq_flags), .src_en(src_en),
        .glob_en(glob_en), .prio_hi(prio_hi), .edge_ext(edge_ext),
        .last_cycle(last_cycle), .ret_in(ret_in), .cfg_wr(cfg_wr),
        .call_req(call_req), .call_vec(call_vec), .flag_clr(flag_clr)
    );

    // requirement data: addresses by polling index
    int vec_tab[12] = '{'h0003, 'h004B, 'h0053, 'h000B, 'h005B, 'h0013,
                        'h0063, 'h001B, 'h006B, 'h0023, 'h002B, 'h0073};

    function automatic bit clears(int i);
        if (i == 0) return edge_ext[0];
        if (i == 5) return edge_ext[1];
        return !(i == 1 || i == 9 || i == 10);
    endfunction

    task automatic check(string tag, bit ok, int act, int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=0x%0h expected=0x%0h at %0t", tag, act, exp, $time);
        end
    endtask

    // behavioural reference model
    logic [11:0] m_samp, m_clr;
    bit m_hi, m_lo, m_call;
    int m_vec;
    always @(posedge clk) begin
        if (!rst_n) begin
            m_samp = '0; m_clr = '0; m_hi = 0; m_lo = 0; m_call = 0; m_vec = 0;
        end else begin
            int bh, bl, pick;
            bit ok;
            bh = -1; bl = -1; pick = -1;
            ok = last_cycle && !ret_in && !cfg_wr;
            for (int i = 0; i < 12; i++) begin
                if (m_samp[i] && src_en[i] && glob_en) begin
                    if (prio_hi[i]) begin if (bh < 0) bh = i; end
                    else if (bl < 0) bl = i;
                end
            end
            if (ok) begin
                if (bh >= 0 && !m_hi) pick = bh;
                else if (bl >= 0 && !m_hi && !m_lo) pick = bl;
            end
            m_clr = '0;
            m_call = (pick >= 0);
            if (pick >= 0) begin
                m_vec = vec_tab[pick];
                if (clears(pick)) m_clr[pick] = 1'b1;
                if (prio_hi[pick]) m_hi = 1; else m_lo = 1;
            end
            if (ret_in) begin
                if (m_hi) m_hi = 0; else m_lo = 0;
            end
            m_samp = irq_flags;
        end
    end

    always @(negedge clk) begin
        if (rst_n && !done) begin
            check({cur_tag, " model call_req"}, call_req == m_call, call_req, m_call);
            check({cur_tag, " model flag_clr"}, flag_clr == m_clr, flag_clr, m_clr);
            if (m_call) check({cur_tag, " model call_vec"}, call_vec == m_vec, call_vec, m_vec);
        end
    end

    // one-cycle flag pulse, result observed two cycles later
    task automatic fire(logic [11:0] f, string tag, bit exp_call, int exp_vec);
        @(negedge clk) irq_flags = f;
        @(negedge clk) irq_flags = '0;
        @(negedge clk);
        check({tag, " call"}, call_req == exp_call, call_req, exp_call);
        if (exp_call) check({tag, " vector"}, call_vec == exp_vec, call_vec, exp_vec);
    endtask

    task automatic ret_pop();
        @(negedge clk) ret_in = 1'b1;
        @(negedge clk) ret_in = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R12 reset call_req", call_req == 0, call_req, 0);
        check("R12 reset flag_clr", flag_clr == 0, flag_clr, 0);

        cur_tag = "R5";
        for (int i = 0; i < 12; i++) begin
            fire(12'(1 << i), "R5", 1, vec_tab[i]);
            check("R11 clear strobe", flag_clr == (clears(i) ? 12'(1 << i) : 12'h0),
                  flag_clr, clears(i) ? (1 << i) : 0);
            ret_pop();
        end

        cur_tag = "R4";
        fire(12'hFFF, "R4 all", 1, 'h0003); ret_pop();
        fire(12'hA00, "R4 pair", 1, 'h0023); ret_pop();
        fire(12'h0C0, "R4 t1/ext4", 1, 'h0063); ret_pop();

        cur_tag = "R3";
        prio_hi = 12'h800;
        fire(12'h801, "R3", 1, 'h0073); ret_pop();
        prio_hi = '0;

        cur_tag = "R2";
        src_en = 12'hFFE;
        fire(12'h001, "R2 src", 0, 0);
        src_en = '1; glob_en = 1'b0;
        fire(12'h008, "R2 glob", 0, 0);
        glob_en = 1'b1;

        cur_tag = "R1";
        @(negedge clk) irq_flags = 12'h008;
        @(negedge clk) irq_flags = '0;
        check("R1 not yet", call_req == 0, call_req, 0);
        @(negedge clk) check("R1 strobe", call_req == 1, call_req, 1);
        @(negedge clk) check("R1 one cycle", call_req == 0, call_req, 0);
        ret_pop();

        cur_tag = "R6";
        @(negedge clk) begin last_cycle = 1'b0; irq_flags = 12'h008; end
        repeat (3) @(negedge clk) check("R6 held off", call_req == 0, call_req, 0);
        last_cycle = 1'b1;
        @(negedge clk) check("R6 released", call_req == 1, call_req, 1);
        irq_flags = '0;
        ret_pop();

        cur_tag = "R8";
        @(negedge clk) begin last_cycle = 1'b0; edge_ext = 2'b00; irq_flags = 12'h020; end
        @(negedge clk) irq_flags = '0;
        @(negedge clk) last_cycle = 1'b1;
        repeat (2) @(negedge clk) check("R8 forgotten", call_req == 0, call_req, 0);
        fire(12'h020, "R8 level ext1", 1, 'h0013);
        check("R11 level ext1 no clear", flag_clr == 0, flag_clr, 0);
        ret_pop();

        cur_tag = "R7";
        @(negedge clk) irq_flags = 12'h008;
        @(negedge clk) begin irq_flags = '0; ret_in = 1'b1; end
        @(negedge clk) ret_in = 1'b0;
        check("R7 ret blocks", call_req == 0, call_req, 0);
        @(negedge clk) irq_flags = 12'h008;
        @(negedge clk) begin irq_flags = '0; cfg_wr = 1'b1; end
        @(negedge clk) cfg_wr = 1'b0;
        check("R7 cfg blocks", call_req == 0, call_req, 0);

        cur_tag = "R9";
        prio_hi = 12'h800;
        fire(12'h008, "R9 low", 1, 'h000B);
        fire(12'h001, "R9 low held", 0, 0);
        fire(12'h800, "R9 preempt", 1, 'h0073);
        fire(12'h800, "R9 high held", 0, 0);
        cur_tag = "R10";
        ret_pop();
        fire(12'h800, "R10 high free", 1, 'h0073);
        ret_pop();
        fire(12'h001, "R10 low still busy", 0, 0);
        ret_pop();
        fire(12'h001, "R10 low free", 1, 'h0003);
        ret_pop();

        cur_tag = "R9 random";
        for (int n = 0; n < 4000; n++) begin
            @(negedge clk);
            irq_flags  = ($urandom % 4 == 0) ? 12'($urandom) : 12'h0;
            src_en     = 12'($urandom) | 12'($urandom);
            prio_hi    = 12'($urandom) & 12'($urandom);
            glob_en    = ($urandom % 10) != 0;
            edge_ext   = 2'($urandom);
            last_cycle = ($urandom % 4) != 0;
            ret_in     = ($urandom % 12) == 0;
            cfg_wr     = ($urandom % 20) == 0;
        end
        @(negedge clk) begin irq_flags = '0; ret_in = 1'b0; cfg_wr = 1'b0; end
        repeat (3) @(negedge clk);

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++; failures++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule